// File: doc/BRIEF.md
# Packet-Dispatch State Sequencer

This block holds the central 3-bit state code of a board controller that services an external Ethernet controller chip. Every functional unit on the board (resets, idler, packet reader, sensor querier, DAC programmer and the two packet transmitters) owns one state code. The sequencer decodes the code into one-hot unit enables, so that only the owning unit may use the shared controller bus. It also emits a one-cycle start pulse to a unit on the first cycle it becomes enabled.

Hand-over is driven by the units. A unit raises its done pulse and proposes the next state. The sequencer takes the proposal only from the enabled unit, and only if it is that unit's legal successor. The idle and reader phases are decided inside the sequencer. Idle advances on the receive-not-empty indication. The reader phase inspects the payload location and type bytes and branches to soft reset, query or program, or drops back to idle.

Top module: `pkt_dispatch_seq`

## Requirements
- R1: While reset is asserted the state is 3'b000 (hard reset), `unit_en` is 8'h01 and `unit_go` is 8'h01.
- R2: `unit_en` is always one-hot, and its set bit index equals the state code.
- R3: `unit_go` equals `unit_en` in the first cycle after a state change and is zero in the cycles after that for the same state.
- R4: A done pulse from the enabled unit, proposing its legal successor, loads that successor at the next clock edge. The legal successors are 000→100, 001→100, 100→101, 110→111, 101→010 and 111→010.
- R5: A done pulse on any `unit_done` bit other than the enabled unit's has no effect on the state.
- R6: A done pulse from the enabled unit that proposes anything other than its legal successor leaves the state unchanged.
- R7: In idle (010) the state moves to 011 at the edge where `rx_pending` is high and holds otherwise. Done pulses from units 2 and 3 are never used.
- R8: In 011 with `hdr_valid` high and `hdr_loc` equal to `BOARD_LOC`, type 8'h52 ('R') selects 001, type 8'h51 ('Q') selects 100 and type 8'h50 ('P') selects 110.
- R9: In 011 with `hdr_valid` high, a location other than `BOARD_LOC` or any other type byte returns the state to 010.
- R10: In 011 the state holds while `hdr_valid` is low. `hdr_valid` has no effect in any other state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| unit_done | input | 8 | Done pulse per unit, bit index = unit state code |
| unit_next | input | 24 | Proposed next state per unit, unit k in bits [3k+2:3k] |
| rx_pending | input | 1 | Receive buffer not empty indication |
| hdr_valid | input | 1 | Payload location and type bytes are valid |
| hdr_loc | input | 8 | Payload location byte |
| hdr_type | input | 8 | Payload type byte |
| state | output | 3 | Current state code |
| unit_en | output | 8 | One-hot unit enable |
| unit_go | output | 8 | One-cycle start pulse per unit |

## Verification
The properties assume that each unit's done pulse and proposal are stable across a clock edge. They also assume that `hdr_loc` and `hdr_type` are valid whenever `hdr_valid` is high. They make no assumption about which units pulse done, so pulses from idle units and illegal proposals are within the checked space. The stimulus changes every input only at the falling clock edge and holds it for a full cycle. It pulses done from disabled units, proposes illegal successors and presents headers outside the reader phase on purpose, so that the hold properties are exercised.

// File: rtl/pkt_seq_pkg.sv
package pkt_seq_pkg;

  localparam int STATE_W = 3;
  localparam int BYTE_W  = 8;

  typedef enum logic [STATE_W-1:0] {
    ST_HARD_RST = 3'b000,
    ST_SOFT_RST = 3'b001,
    ST_IDLE     = 3'b010,
    ST_READ     = 3'b011,
    ST_QUERY    = 3'b100,
    ST_TX_STAT  = 3'b101,
    ST_PROGRAM  = 3'b110,
    ST_TX_DAC   = 3'b111
  } seq_state_e;

  localparam logic [BYTE_W-1:0] TYPE_RESET   = 8'h52;
  localparam logic [BYTE_W-1:0] TYPE_QUERY   = 8'h51;
  localparam logic [BYTE_W-1:0] TYPE_PROGRAM = 8'h50;

  // Successor that a unit is allowed to hand over to.
  // Idle and reader phases are resolved by the sequencer itself.
  function automatic seq_state_e legal_succ(seq_state_e cur);
    case (cur)
      ST_HARD_RST, ST_SOFT_RST: legal_succ = ST_QUERY;
      ST_QUERY:                 legal_succ = ST_TX_STAT;
      ST_PROGRAM:               legal_succ = ST_TX_DAC;
      ST_TX_STAT, ST_TX_DAC:    legal_succ = ST_IDLE;
      default:                  legal_succ = cur;
    endcase
  endfunction

  function automatic logic unit_driven(seq_state_e cur);
    unit_driven = (cur != ST_IDLE) && (cur != ST_READ);
  endfunction

endpackage

// File: rtl/seq_next_logic.sv
module seq_next_logic
  import pkt_seq_pkg::*;
#(
  parameter int                 N_UNITS   = 8,
  parameter logic [BYTE_W-1:0]  BOARD_LOC = 8'h05
) (
  input  seq_state_e                  cur_state,
  input  logic [N_UNITS-1:0]          unit_done,
  input  logic [N_UNITS*STATE_W-1:0]  unit_next,
  input  logic                        rx_pending,
  input  logic                        hdr_valid,
  input  logic [BYTE_W-1:0]           hdr_loc,
  input  logic [BYTE_W-1:0]           hdr_type,
  output seq_state_e                  nxt_state,
  output logic                        load
);

  logic [STATE_W-1:0] sel_prop;
  logic               sel_done;
  seq_state_e         succ;
  seq_state_e         dispatch;

  // Multiplexer over the units: only the enabled unit is looked at.
  always_comb begin
    sel_prop = unit_next[cur_state*STATE_W +: STATE_W];
    sel_done = unit_done[cur_state];
    succ     = legal_succ(cur_state);
  end

  // Packet-type decision for the reader phase.
  always_comb begin
    dispatch = ST_IDLE;
    if (hdr_loc == BOARD_LOC) begin
      case (hdr_type)
        TYPE_RESET:   dispatch = ST_SOFT_RST;
        TYPE_QUERY:   dispatch = ST_QUERY;
        TYPE_PROGRAM: dispatch = ST_PROGRAM;
        default:      dispatch = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    nxt_state = cur_state;
    load      = 1'b0;
    case (cur_state)
      ST_IDLE: begin
        if (rx_pending) begin
          nxt_state = ST_READ;
          load      = 1'b1;
        end
      end
      ST_READ: begin
        if (hdr_valid) begin
          nxt_state = dispatch;
          load      = 1'b1;
        end
      end
      default: begin
        if (unit_driven(cur_state) && sel_done && (sel_prop == succ)) begin
          nxt_state = succ;
          load      = 1'b1;
        end
      end
    endcase
  end

endmodule

// File: rtl/seq_enable_dec.sv
module seq_enable_dec
  import pkt_seq_pkg::*;
#(
  parameter int N_UNITS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seq_state_e         cur_state,
  output logic [N_UNITS-1:0] unit_en,
  output logic [N_UNITS-1:0] unit_go
);

  logic [N_UNITS-1:0] en_prev_q;
  logic [N_UNITS-1:0] en_prev_d;

  for (genvar g = 0; g < N_UNITS; g++) begin : g_dec
    assign unit_en[g] = (cur_state == seq_state_e'(g));
    assign unit_go[g] = unit_en[g] & ~en_prev_q[g];
  end

  always_comb en_prev_d = unit_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_prev_q <= '0;
    else        en_prev_q <= en_prev_d;
  end

endmodule

// File: rtl/pkt_dispatch_seq.sv
module pkt_dispatch_seq
  import pkt_seq_pkg::*;
#(
  parameter logic [7:0] BOARD_LOC = 8'h05,
  localparam int        N_UNITS   = 1 << STATE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_UNITS-1:0]         unit_done,
  input  logic [N_UNITS*STATE_W-1:0] unit_next,
  input  logic                       rx_pending,
  input  logic                       hdr_valid,
  input  logic [BYTE_W-1:0]          hdr_loc,
  input  logic [BYTE_W-1:0]          hdr_type,
  output logic [STATE_W-1:0]         state,
  output logic [N_UNITS-1:0]         unit_en,
  output logic [N_UNITS-1:0]         unit_go
);

  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  seq_state_e state_q;
  seq_state_e state_d;
  logic       state_ld;

  seq_next_logic #(
    .N_UNITS  (N_UNITS),
    .BOARD_LOC(BOARD_LOC)
  ) u_next (
    .cur_state (state_q),
    .unit_done (unit_done),
    .unit_next (unit_next),
    .rx_pending(rx_pending),
    .hdr_valid (hdr_valid),
    .hdr_loc   (hdr_loc),
    .hdr_type  (hdr_type),
    .nxt_state (state_d),
    .load      (state_ld)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)    state_q <= ST_HARD_RST;
    else if (state_ld) state_q <= state_d;
  end

  seq_enable_dec #(
    .N_UNITS(N_UNITS)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .cur_state(state_q),
    .unit_en  (unit_en),
    .unit_go  (unit_go)
  );

  assign state = state_q;

endmodule

// File: rtl/pkt_dispatch_chk.sv
module pkt_dispatch_chk #(
  parameter logic [7:0] BOARD_LOC = 8'h05,
  parameter int         STATE_W   = 3,
  localparam int        N_UNITS   = 1 << STATE_W
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [STATE_W-1:0]         state,
  input logic [N_UNITS-1:0]         unit_en,
  input logic [N_UNITS-1:0]         unit_go,
  input logic [N_UNITS-1:0]         unit_done,
  input logic [N_UNITS*STATE_W-1:0] unit_next,
  input logic                       rx_pending,
  input logic                       hdr_valid,
  input logic [7:0]                 hdr_loc,
  input logic [7:0]                 hdr_type
);

  logic [STATE_W-1:0] own_prop;
  logic               handover;

  always_comb begin
    own_prop = unit_next[state*STATE_W +: STATE_W];
    case (state)
      3'b000, 3'b001: handover = unit_done[state] && own_prop == 3'b100;
      3'b100:         handover = unit_done[state] && own_prop == 3'b101;
      3'b110:         handover = unit_done[state] && own_prop == 3'b111;
      3'b101, 3'b111: handover = unit_done[state] && own_prop == 3'b010;
      default:        handover = 1'b0;
    endcase
  end

  assert_onehot_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(unit_en) == 1 && unit_en[state]);

  assert_go_on_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state) |-> unit_go == unit_en);

  assert_go_only_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_go & ~unit_en) == '0);

  assert_handover_R4: assert property (@(posedge clk) disable iff (!rst_n)
    handover |=> state == $past(own_prop));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 3'b010 && state != 3'b011 && !handover) |=> $stable(state));

  assert_idle_go_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'b010 && rx_pending) |=> state == 3'b011);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'b010 && !rx_pending) |=> state == 3'b010);

  assert_query_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'b011 && hdr_valid && hdr_loc == BOARD_LOC && hdr_type == 8'h51)
    |=> state == 3'b100);

  assert_bad_loc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'b011 && hdr_valid && hdr_loc != BOARD_LOC) |=> state == 3'b010);

  assert_read_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'b011 && !hdr_valid) |=> state == 3'b011);

endmodule

bind pkt_dispatch_seq pkt_dispatch_chk #(
  .BOARD_LOC(BOARD_LOC),
  .STATE_W  (3)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .state     (state),
  .unit_en   (unit_en),
  .unit_go   (unit_go),
  .unit_done (unit_done),
  .unit_next (unit_next),
  .rx_pending(rx_pending),
  .hdr_valid (hdr_valid),
  .hdr_loc   (hdr_loc),
  .hdr_type  (hdr_type)
);

// File: tb/sim_pkt_dispatch_seq.sv
`timescale 1ns/1ps
module sim_pkt_dispatch_seq;

  localparam logic [7:0] LOC = 8'h05;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  unit_done;
  logic [23:0] unit_next;
  logic        rx_pending;
  logic        hdr_valid;
  logic [7:0]  hdr_loc;
  logic [7:0]  hdr_type;
  logic [2:0]  state;
  logic [7:0]  unit_en;
  logic [7:0]  unit_go;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pkt_dispatch_seq #(.BOARD_LOC(LOC)) u0 (
    .clk(clk), .rst_n(rst_n), .unit_done(unit_done), .unit_next(unit_next),
    .rx_pending(rx_pending), .hdr_valid(hdr_valid), .hdr_loc(hdr_loc),
    .hdr_type(hdr_type), .state(state), .unit_en(unit_en), .unit_go(unit_go)
  );

  task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // state plus its one-hot enable (R2)
  task automatic expect_st(input logic [2:0] s, input string what);
    chk8({5'd0, state}, {5'd0, s}, what);
    chk8(unit_en, 8'h01 << s, {what, " R2 enable"});
  endtask

  task automatic fire(input int u, input logic [2:0] nxt);
    unit_done[u] = 1'b1;
    unit_next[u*3 +: 3] = nxt;
    @(negedge clk);
    unit_done = '0;
    unit_next = '0;
  endtask

  task automatic rx_pulse();
    rx_pending = 1'b1;
    @(negedge clk);
    rx_pending = 1'b0;
  endtask

  task automatic hdr_pulse(input logic [7:0] loc, input logic [7:0] typ);
    hdr_valid = 1'b1; hdr_loc = loc; hdr_type = typ;
    @(negedge clk);
    hdr_valid = 1'b0; hdr_loc = '0; hdr_type = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; unit_done = '0; unit_next = '0;
    rx_pending = 0; hdr_valid = 0; hdr_loc = '0; hdr_type = '0;
    repeat (3) @(negedge clk);
    expect_st(3'b000, "R1 reset state");
    chk8(unit_go, 8'h01, "R1 go in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_st(3'b000, "R1 after release");
    chk8(unit_go, 8'h00, "R3 go ended");
  endtask

  task automatic t_boot();
    fire(0, 3'b100);
    expect_st(3'b100, "R4 hard reset to query");
    chk8(unit_go, 8'h10, "R3 go on query");
    @(negedge clk);
    chk8(unit_go, 8'h00, "R3 go one cycle");
    fire(4, 3'b101);
    expect_st(3'b101, "R4 query to tx status");
    fire(5, 3'b010);
    expect_st(3'b010, "R4 tx status to idle");
  endtask

  task automatic t_idle_hold();
    repeat (2) @(negedge clk);
    expect_st(3'b010, "R7 idle holds");
    fire(3, 3'b100);
    expect_st(3'b010, "R5 reader done while idle");
    fire(2, 3'b011);
    expect_st(3'b010, "R7 idle unit done unused");
    hdr_pulse(LOC, 8'h50);
    expect_st(3'b010, "R10 header outside reader");
  endtask

  task automatic t_query();
    rx_pulse();
    expect_st(3'b011, "R7 idle to read");
    chk8(unit_go, 8'h08, "R3 go on reader");
    repeat (2) @(negedge clk);
    expect_st(3'b011, "R10 reader waits");
    hdr_pulse(LOC, 8'h51);
    expect_st(3'b100, "R8 type Q");
    fire(5, 3'b010);
    expect_st(3'b100, "R5 disabled unit done");
    fire(4, 3'b110);
    expect_st(3'b100, "R6 illegal proposal");
    fire(4, 3'b101);
    fire(5, 3'b010);
    expect_st(3'b010, "R4 query loop back");
  endtask

  task automatic t_program();
    rx_pulse();
    hdr_pulse(LOC, 8'h50);
    expect_st(3'b110, "R8 type P");
    chk8(unit_go, 8'h40, "R3 go on program");
    fire(6, 3'b010);
    expect_st(3'b110, "R6 program skips tx");
    fire(6, 3'b111);
    expect_st(3'b111, "R4 program to tx dac");
    fire(7, 3'b010);
    expect_st(3'b010, "R4 tx dac to idle");
  endtask

  task automatic t_soft();
    rx_pulse();
    hdr_pulse(LOC, 8'h52);
    expect_st(3'b001, "R8 type R");
    chk8(unit_go, 8'h02, "R3 go on soft reset");
    fire(1, 3'b100);
    expect_st(3'b100, "R4 soft reset to query");
    fire(4, 3'b101);
    fire(5, 3'b010);
    expect_st(3'b010, "R4 back to idle");
  endtask

  task automatic t_rejects();
    rx_pulse();
    hdr_pulse(8'h06, 8'h51);
    expect_st(3'b010, "R9 wrong location");
    rx_pulse();
    hdr_pulse(LOC, 8'h58);
    expect_st(3'b010, "R9 unknown type");
  endtask

  initial begin
    t_reset();
    t_boot();
    t_idle_hold();
    t_query();
    t_program();
    t_soft();
    t_rejects();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule